// File: doc/BRIEF.md
# Truncated fixed-point dot-product accumulator

This block evaluates a short dot product of single-precision floats plus a starting value: result = seed + x0*y0 + x1*y1. It does not chain floating-point adders. It forms each exact 48-bit mantissa product and shifts it into a narrow signed fixed-point register. The register spans bit weights 2^4 down to 2^-6, with two guard bits above the top weight and a sign bit. Its 14 bits fit inside one 16-bit carry chunk. All rounding happens while a product is aligned into the window. Turning the sum back into binary32 is exact, because the window is narrower than the 24-bit significand.

While the synchronous active-low reset is held, the seed is aligned and loaded into the register. Once reset is released, one (x, y) pair is taken on each rising edge, for NTERMS edges. The following edge registers the converted sum on `result_o`. After that the block is frozen until the next reset. The result is therefore ready three rising edges after release.

Top module: `fxdot_acc`

## Requirements
- R1: While `rst_n` is low, `result_o` reads 0x00000000 one edge later and the accumulator is loaded with the aligned `seed_i`. The first edge after release shows the converted seed on `result_o`.
- R2: With rst_n released, the pairs on `x_i`/`y_i` at rising edges 1 and 2 are multiplied and added. From edge 3 onward `result_o` equals seed + x0*y0 + x1*y1 in binary32, exact whenever each value lies on the 2^-6 grid and within the window.
- R3: Product and seed bits below weight 2^-6 are dropped toward zero in magnitude, for both signs. A product of magnitude below 2^-6 contributes nothing.
- R4: A product or seed whose magnitude exceeds 8191*2^-6 is clamped to ±8191*2^-6 (0x42FFF800 / 0xC2FFF800). The running sum saturates to the same symmetric limits.
- R5: An operand with biased exponent 0 (zero or subnormal) makes its product contribute 0, whatever the other operand is. A seed with exponent 0 loads 0.
- R6: An operand or seed with biased exponent 255 (infinity or NaN) makes the result the quiet NaN 0x7FC00000 for the rest of the frame.
- R7: A sum of exactly zero, including one reached by cancellation, yields +0.0 (0x00000000).
- R8: After NTERMS pairs, further `x_i`/`y_i` values, including infinities, have no effect, and `result_o` holds until the next reset.
- R9: A nonzero sum is converted with sign = sum sign, biased exponent = 121 + position of the leading one in the magnitude, and fraction = the bits below that leading one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the seed |
| seed_i | input | 32 | Binary32 starting value, sampled during reset |
| x_i | input | 32 | Binary32 left operand of the current term |
| y_i | input | 32 | Binary32 right operand of the current term |
| result_o | output | 32 | Binary32 sum, final from the third edge after release |

## Verification
The converted seed appears one rising edge after reset release. The partial sum after the first term appears after the second edge. The final sum appears after the third edge and stays until reset. The bench drives every input on falling edges. It reads the seed value one falling edge after release and the final value three falling edges after release, so each sample falls half a cycle after the register that drives it has settled. The hold check keeps feeding large operands for several more cycles and re-reads the output. The reset check reads the output one falling edge after reset is asserted.

// File: rtl/fxdot_pkg.sv
// Package: binary32 field layout and shared constants for the fixed-point
// dot-product accumulator. Assumes the IEEE754 single-precision layout.
package fxdot_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int MANT_W = FRAC_W + 1;
    localparam int BIAS   = 127;
    localparam int SH_W   = 12;   // signed alignment shift width
    localparam logic [31:0] QNAN = 32'h7FC0_0000;

    typedef struct packed {
        logic              sgn;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } f32_t;
endpackage

// File: rtl/fxdot_align.sv
// Module: fxdot_align
// Places an unsigned magnitude, scaled by 2^shift_i in units of the window
// lsb, into a signed ACC_W-bit two's complement term. Bits below the lsb are
// truncated and values beyond the largest symmetric magnitude are clamped.
// Assumes the magnitude has its leading one at bit TOP or above whenever
// zero_i is low, and that TOP >= ACC_W-1, so every shift >= 0 saturates.
module fxdot_align import fxdot_pkg::*; #(
    parameter int MAG_W = 48,
    parameter int TOP   = 46,
    parameter int ACC_W = 14
) (
    input  logic [MAG_W-1:0]       mag_i,
    input  logic signed [SH_W-1:0] shift_i,
    input  logic                   neg_i,
    input  logic                   zero_i,
    output logic [ACC_W-1:0]       term_o
);
    localparam int SAT_SH = ACC_W - 1 - TOP;
    localparam logic signed [SH_W-1:0] SAT_SH_V = SH_W'(SAT_SH);
    localparam logic [MAG_W-1:0] MAXV_M = {{(MAG_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] MAXV_A = {1'b0, {(ACC_W-1){1'b1}}};

    logic [SH_W-1:0]  rsh;
    logic [MAG_W-1:0] shifted;
    logic [ACC_W-1:0] mag_al;

    // Purpose: compute the clamped, truncated magnitude and apply the sign.
    always_comb begin
        rsh     = -shift_i;
        shifted = mag_i >> rsh;
        if (zero_i) begin
            mag_al = '0;
        end else if (shift_i >= SAT_SH_V) begin
            mag_al = MAXV_A;
        end else if (rsh >= SH_W'(MAG_W)) begin
            mag_al = '0;
        end else if (shifted > MAXV_M) begin
            mag_al = MAXV_A;
        end else begin
            mag_al = shifted[ACC_W-1:0];
        end
        term_o = neg_i ? (~mag_al + 1'b1) : mag_al;
    end
endmodule

// File: rtl/fxdot_to_f32.sv
// Module: fxdot_to_f32
// Converts the signed fixed-point sum (lsb weight 2^LSB_WT) to binary32 with
// a leading-one search. Exact, because the magnitude is narrower than the
// significand. Assumes |acc_i| never reaches 2^(ACC_W-1), which the
// symmetric saturation upstream guarantees.
module fxdot_to_f32 import fxdot_pkg::*; #(
    parameter int ACC_W  = 14,
    parameter int LSB_WT = -6
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic             nan_i,
    output logic [31:0]      f_o
);
    localparam int LW   = $clog2(ACC_W);
    localparam int SA_W = $clog2(FRAC_W + 1);

    logic              neg;
    logic [ACC_W-2:0]  mag;
    logic [LW-1:0]     lead;
    logic [SA_W-1:0]   sh;
    logic [EXP_W-1:0]  exp_v;
    logic [FRAC_W-1:0] frac_v;

    // Purpose: magnitude, leading-one position and packing of the fields.
    always_comb begin
        neg  = acc_i[ACC_W-1];
        mag  = neg ? (~acc_i[ACC_W-2:0] + 1'b1) : acc_i[ACC_W-2:0];
        lead = '0;
        for (int i = 0; i < ACC_W - 1; i++) begin
            if (mag[i]) lead = LW'(i);
        end
        sh     = SA_W'(FRAC_W) - SA_W'(lead);
        exp_v  = EXP_W'(lead) + EXP_W'(BIAS + LSB_WT);
        frac_v = FRAC_W'(mag) << sh;
        if (nan_i) begin
            f_o = QNAN;
        end else if (mag == '0) begin
            f_o = 32'h0;
        end else begin
            f_o = {neg, exp_v, frac_v};
        end
    end
endmodule

// File: rtl/fxdot_acc.sv
// Module: fxdot_acc (top)
// Dot-product accumulator: seed + sum of NTERMS exact x*y products kept in a
// narrow signed fixed-point window, then one exact conversion to binary32.
// The seed loads during synchronous active-low reset. One pair is consumed
// per edge afterwards, and the result register follows one edge later.
// Assumes ACC_W-1 <= FRAC_W+1 and BIAS+LSB_WT > 0.
module fxdot_acc import fxdot_pkg::*; #(
    parameter int MSB_WT   = 4,
    parameter int LSB_WT   = -6,
    parameter int OVF_BITS = 2,
    parameter int NTERMS   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] seed_i,
    input  logic [31:0] x_i,
    input  logic [31:0] y_i,
    output logic [31:0] result_o
);
    localparam int ACC_W = OVF_BITS + MSB_WT - LSB_WT + 2;
    localparam int CNT_W = $clog2(NTERMS + 1);
    localparam int PW    = 2 * MANT_W;
    localparam logic signed [SH_W-1:0] PROD_OFF = SH_W'(2*BIAS + 2*FRAC_W + LSB_WT);
    localparam logic signed [SH_W-1:0] SEED_OFF = SH_W'(BIAS + FRAC_W + LSB_WT);
    localparam logic signed [ACC_W:0] POS_LIM = {2'b00, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W:0] NEG_LIM = {2'b11, {(ACC_W-2){1'b0}}, 1'b1};

    f32_t xf, yf, sf;
    logic [PW-1:0]          prod;
    logic signed [SH_W-1:0] prod_sh, seed_sh;
    logic                   x_spec, y_spec, s_spec;
    logic [ACC_W-1:0]       prod_term, seed_term, acc_sum;
    logic signed [ACC_W:0]  wide;
    logic [31:0]            conv;

    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             nan_q;
    logic [31:0]      result_q;

    assign xf = x_i;
    assign yf = y_i;
    assign sf = seed_i;

    // Purpose: exact significand product and its alignment shifts.
    always_comb begin
        prod    = {1'b1, xf.frac} * {1'b1, yf.frac};
        prod_sh = SH_W'(xf.exp) + SH_W'(yf.exp) - PROD_OFF;
        seed_sh = SH_W'(sf.exp) - SEED_OFF;
        x_spec  = &xf.exp;
        y_spec  = &yf.exp;
        s_spec  = &sf.exp;
    end

    fxdot_align #(.MAG_W(PW), .TOP(2*FRAC_W), .ACC_W(ACC_W)) u_prod_align (
        .mag_i   (prod),
        .shift_i (prod_sh),
        .neg_i   (xf.sgn ^ yf.sgn),
        .zero_i  ((xf.exp == '0) || (yf.exp == '0)),
        .term_o  (prod_term)
    );

    fxdot_align #(.MAG_W(MANT_W), .TOP(FRAC_W), .ACC_W(ACC_W)) u_seed_align (
        .mag_i   ({1'b1, sf.frac}),
        .shift_i (seed_sh),
        .neg_i   (sf.sgn),
        .zero_i  (sf.exp == '0),
        .term_o  (seed_term)
    );

    // Purpose: saturating signed addition of the new term to the sum.
    always_comb begin
        wide = $signed({acc_q[ACC_W-1], acc_q}) + $signed({prod_term[ACC_W-1], prod_term});
        if (wide > POS_LIM)       acc_sum = POS_LIM[ACC_W-1:0];
        else if (wide < NEG_LIM)  acc_sum = NEG_LIM[ACC_W-1:0];
        else                      acc_sum = wide[ACC_W-1:0];
    end

    fxdot_to_f32 #(.ACC_W(ACC_W), .LSB_WT(LSB_WT)) u_conv (
        .acc_i (acc_q),
        .nan_i (nan_q),
        .f_o   (conv)
    );

    // Purpose: seed load in reset, term accumulation, result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= seed_term;
            nan_q    <= s_spec;
            cnt_q    <= '0;
            result_q <= 32'h0;
        end else begin
            if (cnt_q != CNT_W'(NTERMS)) begin
                acc_q <= acc_sum;
                nan_q <= nan_q | x_spec | y_spec;
                cnt_q <= cnt_q + 1'b1;
            end
            result_q <= conv;
        end
    end

    assign result_o = result_q;
endmodule

// File: rtl/fxdot_acc_chk.sv
// Module: fxdot_acc_chk
// Property checker bound to fxdot_acc. It watches the sum, the term counter,
// the NaN flag and the result port. Assumes the reset polarity of the top.
module fxdot_acc_chk import fxdot_pkg::*; #(
    parameter int ACC_W  = 14,
    parameter int NTERMS = 2,
    parameter int CNT_W  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ACC_W-1:0] acc_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             nan_q,
    input logic [31:0]      result_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> result_o == 32'h0);

    // R4
    sym_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q != {1'b1, {(ACC_W-1){1'b0}}});

    // R6
    nan_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nan_q |=> nan_q);

    // R6
    nan_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nan_q |=> result_o == QNAN);

    // R7
    zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q == '0 && !nan_q) |=> result_o == 32'h0);

    // R9
    sign_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q[ACC_W-1] && !nan_q) |=> result_o[31]);

    // R8
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(NTERMS)) |=> ($stable(acc_q) && cnt_q == CNT_W'(NTERMS)));
endmodule

bind fxdot_acc fxdot_acc_chk #(.ACC_W(ACC_W), .NTERMS(NTERMS), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_q    (acc_q),
    .cnt_q    (cnt_q),
    .nan_q    (nan_q),
    .result_o (result_o)
);

// File: tb/fxdot_acc_tb.sv
// Directed bench for fxdot_acc: one task per scenario, expected values
// worked out by hand from the requirements.
module fxdot_acc_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] seed_i = '0, x_i = '0, y_i = '0;
    logic [31:0] result_o;
    int n_cmp = 0;
    int n_bad = 0;

    fxdot_acc u_dut (.clk(clk), .rst_n(rst_n), .seed_i(seed_i),
                     .x_i(x_i), .y_i(y_i), .result_o(result_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One frame: reset with seed, two terms, result three edges after release.
    task automatic run_frame(input logic [31:0] s, a0, b0, a1, b1,
                             output logic [31:0] first, output logic [31:0] last);
        rst_n = 1'b0; seed_i = s; x_i = '0; y_i = '0;
        @(negedge clk);
        check("R1 reset clears result", result_o, 32'h0);
        rst_n = 1'b1; x_i = a0; y_i = b0;
        @(negedge clk);
        first = result_o;
        x_i = a1; y_i = b1;
        @(negedge clk);
        x_i = '0; y_i = '0;
        @(negedge clk);
        last = result_o;
    endtask

    task automatic t_basic;
        logic [31:0] f, l;
        run_frame(32'h3F800000, 32'h40000000, 32'h40400000, 32'h3F000000, 32'hC0800000, f, l);
        check("R1 seed loaded", f, 32'h3F800000);
        check("R2 1+2*3+0.5*-4", l, 32'h40A00000);
        x_i = 32'h41800000; y_i = 32'h7F800000;
        repeat (4) @(negedge clk);
        check("R8 late inputs ignored", result_o, 32'h40A00000);
        x_i = '0; y_i = '0;
    endtask

    task automatic t_trunc;
        logic [31:0] f, l;
        run_frame(32'h0, 32'h3F808000, 32'h3F800000, 32'h0, 32'h0, f, l);
        check("R3 positive truncation", l, 32'h3F800000);
        run_frame(32'h0, 32'hBF808000, 32'h3F800000, 32'h0, 32'h0, f, l);
        check("R3 negative truncation", l, 32'hBF800000);
        run_frame(32'h0, 32'h3C000000, 32'h3F800000, 32'h0, 32'h0, f, l);
        check("R3 sub-lsb product", l, 32'h00000000);
    endtask

    task automatic t_sat;
        logic [31:0] f, l;
        run_frame(32'h0, 32'h41800000, 32'h41800000, 32'h0, 32'h0, f, l);
        check("R4 product clamp +", l, 32'h42FFF800);
        run_frame(32'h0, 32'hC1800000, 32'h41800000, 32'h0, 32'h0, f, l);
        check("R4 product clamp -", l, 32'hC2FFF800);
        run_frame(32'h42C80000, 32'h41200000, 32'h40400000, 32'h0, 32'h0, f, l);
        check("R4 sum clamp", l, 32'h42FFF800);
    endtask

    task automatic t_zero;
        logic [31:0] f, l;
        run_frame(32'h40000000, 32'h00000001, 32'h7F000000, 32'h00000000, 32'h7F000000, f, l);
        check("R5 zero/subnormal operands", l, 32'h40000000);
    endtask

    task automatic t_nan;
        logic [31:0] f, l;
        run_frame(32'h3F800000, 32'h7F800000, 32'h3F800000, 32'h0, 32'h0, f, l);
        check("R6 infinite x", l, 32'h7FC00000);
        run_frame(32'h7FC12345, 32'h3F800000, 32'h3F800000, 32'h0, 32'h0, f, l);
        check("R6 NaN seed", l, 32'h7FC00000);
        run_frame(32'h3F800000, 32'h0, 32'h0, 32'h3F800000, 32'hFFC00000, f, l);
        check("R6 NaN second y", l, 32'h7FC00000);
    endtask

    task automatic t_cancel;
        logic [31:0] f, l;
        run_frame(32'hC0A00000, 32'h40000000, 32'h40000000, 32'h3F000000, 32'h40000000, f, l);
        check("R7 cancellation to +0", l, 32'h00000000);
    endtask

    task automatic t_exact;
        logic [31:0] f, l;
        run_frame(32'h0, 32'h3C800000, 32'h3F800000, 32'h0, 32'h0, f, l);
        check("R9 lsb weight", l, 32'h3C800000);
        run_frame(32'hBF400000, 32'h0, 32'h0, 32'h0, 32'h0, f, l);
        check("R9 negative seed only", l, 32'hBF400000);
        run_frame(32'h0, 32'h40400000, 32'hBFC00000, 32'h3E800000, 32'h3E800000, f, l);
        check("R9 mixed -4.4375", l, 32'hC08E0000);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_basic();
        t_trunc();
        t_sat();
        t_zero();
        t_nan();
        t_cancel();
        t_exact();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule